// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits on the read path of a nonvolatile memory, between the storage array and the output data bus. While a programming period is running, the array cannot be read, so the block answers host reads with a status word instead. The host can use this word to find out when the write has finished. Two completion tests are available at the same time:

- The most significant data bit returns the inverse of the corresponding bit of the byte that was loaded last.
- A second bit inverts after every completed read access.

Once the busy flag drops, reads pass the array data through unchanged.

The busy flag covers every interval in which the internal timer runs. This includes the dummy timer interval that starts when a write is blocked by write protection, so reads during that interval are also answered with status. The host may start polling at any time during the period.

A read access is open while both the active-low output enable and the active-low chip enable are low. It closes when either one goes high. Toggling either enable therefore counts as a new access. All inputs are sampled on the rising clock edge. The read data output is combinational from the inputs and the internal state.

Top module: `wr_status_responder`

## Requirements
- R1: While busy_i is 0, rd_data_o equals array_data_i in the same cycle. This holds after reset and in the cycle right after a programming period ends.
- R2: While busy_i is 1, bit 7 of rd_data_o is the inverse of bit 7 of the last captured byte. That byte resets to 0x00, so a programming period right after reset reads bit 7 as 1.
- R3: While busy_i is 1, bits 5 down to 0 of rd_data_o equal the same bits of the last captured byte, and array_data_i has no effect on rd_data_o.
- R4: Bit 6 of rd_data_o reads 0 from the first cycle of every programming period (a rising edge of busy_i) until the first access of that period closes, however long the host waits before it polls.
- R5: While busy_i stays 1, bit 6 inverts in the cycle after an access closes and holds its value for the whole of an open access. An access is open while oe_ni and ce_ni are both 0.
- R6: Closing an access by raising ce_ni while oe_ni stays low advances bit 6 in the same way as closing it by raising oe_ni.
- R7: load_i captures load_data_i as the last byte only while busy_i is 0. A load while busy_i is 1 is ignored, so bits 7 and 5..0 do not change during a programming period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Programming period (or dummy timer interval) in progress |
| oe_ni | input | 1 | Output enable, active low |
| ce_ni | input | 1 | Chip enable, active low |
| load_i | input | 1 | A byte is loaded into the write page this cycle |
| load_data_i | input | 8 | The byte being loaded |
| array_data_i | input | 8 | Data read from the storage array |
| rd_data_o | output | 8 | Data returned to the host bus |

## Verification
The bench builds the block with its default parameters: an 8-bit data word, the inverted-data flag on bit 7 and the alternating flag on bit 6, which is the layout the requirements describe. With these defaults every field position can be checked by exact byte values. The directed part covers both ways of closing an access, the gap between the start of busy and the first poll, loads and array changes during busy, and the handover back to array data. The random part keeps busy in long phases and changes both enables independently, so accesses straddle the start and the end of programming periods.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  parameter int unsigned DEF_DATA_W     = 8;
  parameter int unsigned DEF_POLL_BIT   = 7;
  parameter int unsigned DEF_TOGGLE_BIT = 6;

  typedef enum logic {
    ACC_IDLE = 1'b0,
    ACC_OPEN = 1'b1
  } acc_state_e;
endpackage

// File: rtl/wcs_access_tracker.sv
module wcs_access_tracker
  import wcs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_ni,
  input  logic ce_ni,
  output logic acc_close_o
);
  acc_state_e state_q, state_d;
  logic       open_now;

  assign open_now = ~oe_ni & ~ce_ni;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACC_IDLE: if (open_now)  state_d = ACC_OPEN;
      ACC_OPEN: if (!open_now) state_d = ACC_IDLE;
      default:  state_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ACC_IDLE;
    else         state_q <= state_d;
  end

  // raising either enable ends the access
  assign acc_close_o = (state_q == ACC_OPEN) && !open_now;
endmodule

// File: rtl/wcs_status_regs.sv
module wcs_status_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              acc_close_i,
  output logic [DATA_W-1:0] last_o,
  output logic              tog_o,
  output logic              run_o
);
  logic [DATA_W-1:0] last_q;
  logic              tog_q;
  logic              run_q;
  logic              start;

  assign start = busy_i & ~run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      tog_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q <= busy_i;
      if (load_i && !busy_i) last_q <= load_data_i;
      if (start)                      tog_q <= 1'b0;
      else if (busy_i && acc_close_i) tog_q <= ~tog_q;
    end
  end

  assign last_o = last_q;
  assign tog_o  = tog_q;
  assign run_o  = run_q;
endmodule

// File: rtl/wcs_read_mux.sv
module wcs_read_mux #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POLL_BIT   = 7,
  parameter int unsigned TOGGLE_BIT = 6
) (
  input  logic              busy_i,
  input  logic              run_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] last_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] status;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign status[b] = ~last_i[b];
    end else if (b == TOGGLE_BIT) begin : g_tog
      // first cycle of a period: register not yet cleared
      assign status[b] = run_i & tog_i;
    end else begin : g_echo
      assign status[b] = last_i[b];
    end
  end

  assign data_o = busy_i ? status : array_i;
endmodule

// File: rtl/wr_status_responder.sv
module wr_status_responder
  import wcs_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned POLL_BIT   = DEF_POLL_BIT,
  parameter int unsigned TOGGLE_BIT = DEF_TOGGLE_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              oe_ni,
  input  logic              ce_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              acc_close;
  logic [DATA_W-1:0] last;
  logic              tog;
  logic              run;

  wcs_access_tracker u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .oe_ni       (oe_ni),
    .ce_ni       (ce_ni),
    .acc_close_o (acc_close)
  );

  wcs_status_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .acc_close_i (acc_close),
    .last_o      (last),
    .tog_o       (tog),
    .run_o       (run)
  );

  wcs_read_mux #(
    .DATA_W    (DATA_W),
    .POLL_BIT  (POLL_BIT),
    .TOGGLE_BIT(TOGGLE_BIT)
  ) u_mux (
    .busy_i  (busy_i),
    .run_i   (run),
    .tog_i   (tog),
    .last_i  (last),
    .array_i (array_data_i),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POLL_BIT   = 7,
  parameter int unsigned TOGGLE_BIT = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              oe_ni,
  input logic              ce_ni,
  input logic              load_i,
  input logic [DATA_W-1:0] load_data_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] shadow_q;
  logic              pb_q, pb2_q, pa_q;
  logic              act;

  assign act = ~oe_ni & ~ce_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      pb_q     <= 1'b0;
      pb2_q    <= 1'b0;
      pa_q     <= 1'b0;
    end else begin
      if (load_i && !busy_i) shadow_q <= load_data_i;
      pb_q  <= busy_i;
      pb2_q <= pb_q;
      pa_q  <= act;
    end
  end

  assert_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> rd_data_o == array_data_i);

  assert_poll_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> rd_data_o[POLL_BIT] != shadow_q[POLL_BIT]);

  assert_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !pb_q) |-> !rd_data_o[TOGGLE_BIT]);

  assert_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && pb_q && pa_q && !act) |=>
      (!busy_i || rd_data_o[TOGGLE_BIT] != $past(rd_data_o[TOGGLE_BIT])));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && pb_q && pb2_q && act && pa_q) |-> $stable(rd_data_o[TOGGLE_BIT]));

  assert_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && pb_q) |-> $stable(rd_data_o[POLL_BIT]));
endmodule

bind wr_status_responder wcs_checker #(
  .DATA_W    (DATA_W),
  .POLL_BIT  (POLL_BIT),
  .TOGGLE_BIT(TOGGLE_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_i),
  .oe_ni        (oe_ni),
  .ce_ni        (ce_ni),
  .load_i       (load_i),
  .load_data_i  (load_data_i),
  .array_data_i (array_data_i),
  .rd_data_o    (rd_data_o)
);

// File: tb/wr_status_responder_bench.sv
`timescale 1ns/1ps
module wr_status_responder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       busy_i = 1'b0;
  logic       oe_ni = 1'b1;
  logic       ce_ni = 1'b1;
  logic       load_i = 1'b0;
  logic [7:0] load_data_i = '0;
  logic [7:0] array_data_i = '0;
  logic [7:0] rd_data_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state, from the requirements
  logic [7:0] m_last = '0;
  logic       m_tog = 1'b0, m_run = 1'b0, m_open = 1'b0;

  always #2 clk_i = ~clk_i;

  wr_status_responder u_wr_status_responder (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .oe_ni(oe_ni),
    .ce_ni(ce_ni), .load_i(load_i), .load_data_i(load_data_i),
    .array_data_i(array_data_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [7:0] expect_rd();
    if (!busy_i) return array_data_i;
    return {~m_last[7], m_run & m_tog, m_last[5:0]};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    logic act;
    act = ~oe_ni & ~ce_ni;
    if (busy_i && !m_run)               m_tog = 1'b0;
    else if (busy_i && m_open && !act)  m_tog = ~m_tog;
    if (load_i && !busy_i) m_last = load_data_i;
    m_run  = busy_i;
    m_open = act;
  endtask

  // call right after a negedge with inputs set; returns at the next negedge
  task automatic probe(string tag, logic [7:0] lit, bit use_lit);
    #1;
    check(tag, rd_data_o, use_lit ? lit : expect_rd());
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic set_in(bit b, bit oe, bit ce, bit ld, logic [7:0] ldd, logic [7:0] arr);
    busy_i = b; oe_ni = oe; ce_ni = ce; load_i = ld;
    load_data_i = ldd; array_data_i = arr;
  endtask

  initial begin
    int seed;
    int phase;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    set_in(0, 1, 1, 0, 8'h00, 8'h3C);
    probe("R1 reset passthrough", 8'h3C, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    set_in(0, 1, 1, 1, 8'hA5, 8'h11);
    probe("R1 idle passthrough", 8'h11, 1);
    set_in(0, 1, 1, 0, 8'h00, 8'h11);
    probe("R1 idle", 8'h11, 1);
    // A5 -> bit7 inverted 0, bit6 0, low bits 25
    set_in(1, 1, 1, 0, 8'h00, 8'h77);
    probe("R2 R3 R4 first busy cycle", 8'h25, 1);
    for (int i = 0; i < 5; i++) begin
      set_in(1, 1, 1, 0, 8'h00, 8'($urandom));
      probe("R3 array ignored, R4 late poll", 8'h25, 1);
    end
    set_in(1, 1, 1, 1, 8'hFF, 8'h00);
    probe("R7 load while busy", 8'h25, 1);
    set_in(1, 0, 0, 0, 8'h00, 8'h00);
    probe("R4 R7 first access open", 8'h25, 1);
    probe("R5 hold while open", 8'h25, 1);
    set_in(1, 1, 0, 0, 8'h00, 8'h00);
    probe("R5 close cycle", 8'h25, 1);
    probe("R5 after oe close", 8'h65, 1);
    set_in(1, 0, 0, 0, 8'h00, 8'h00);
    probe("R5 open again", 8'h65, 1);
    set_in(1, 0, 1, 0, 8'h00, 8'h00);
    probe("R6 ce close cycle", 8'h65, 1);
    probe("R6 after ce close", 8'h25, 1);
    set_in(1, 0, 0, 0, 8'h00, 8'h00);
    probe("R6 open", 8'h25, 1);
    set_in(1, 0, 1, 0, 8'h00, 8'h00);
    probe("R6 close", 8'h25, 1);
    set_in(0, 1, 1, 0, 8'h00, 8'h5A);
    probe("R1 after completion", 8'h5A, 1);
    set_in(1, 1, 1, 0, 8'h00, 8'h5A);
    probe("R4 new period clears toggle", 8'h25, 1);
    set_in(0, 1, 1, 1, 8'h3F, 8'hC3);
    probe("R7 idle load", 8'hC3, 1);
    set_in(1, 1, 1, 0, 8'h00, 8'hC3);
    probe("R2 R3 new last byte", 8'hBF, 1);

    // random phase
    phase = 0;
    for (int i = 0; i < 4000; i++) begin
      logic oe, ce;
      if (phase == 0) begin
        busy_i = ~busy_i;
        phase  = 20 + ($urandom % 180);
      end
      phase--;
      oe = ($urandom % 4 == 0) ? ~oe_ni : oe_ni;
      ce = ($urandom % 6 == 0) ? ~ce_ni : ce_ni;
      set_in(busy_i, oe, ce, ($urandom % 8) == 0, 8'($urandom), 8'($urandom));
      #1;
      begin
        logic [7:0] e;
        e = expect_rd();
        if (!busy_i)                 check("R1 random", rd_data_o, e);
        else if (rd_data_o[7] !== e[7]) check("R2 random", rd_data_o, e);
        else if (rd_data_o[6] !== e[6]) check("R5 random", rd_data_o, e);
        else                          check("R3 R7 random", rd_data_o, e);
      end
      @(posedge clk_i);
      model_step();
      @(negedge clk_i);
    end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #700000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule